// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with One Match Channel

This block is a general-purpose timer on a simple 32-bit register bus: one write strobe, one read strobe, a byte address and separate write and read data words. A counter counts up from zero to a programmable limit and then wraps to zero. A programmable clock divider sets its count rate. The counter is either 16 or 32 bits wide, chosen by a parameter. The limit, counter and match registers are only that wide. Software can therefore find the width by writing all ones to the limit register and reading it back.

Each wrap produces an update event. An update event sets the update flag and loads the buffered limit. Software can also force an update event, and that is the only way to make a new divider value take effect. A match channel sets its own flag when the counter steps onto the match value. The counter keeps running after a match, so the match value works modulo the limit. Both flags can drive a single registered interrupt line through per-flag enables. Control bits provide count enable, suppression of update events at wrap, a one-pulse mode that stops the counter at the next update event, and buffering of the limit register.

Top module: `utimer`

## Requirements
- R1: After reset the control, enable, status and counter registers read 0, the limit register reads all ones within the counter width, and `irqOut` is 0.
- R2: The register map is: control 0x00, interrupt enable 0x0C, status 0x10, event trigger 0x14, counter 0x24, divider 0x28, limit 0x2C, match 0x34. The limit, counter and match registers keep only the low CNT_W bits and read back zero-extended, so all ones written to the limit reads 0x0000FFFF when CNT_W is 16. The divider register keeps its low 16 bits. The event trigger register reads 0.
- R3: While control bit 0 (enable) is set, the counter advances once every D+1 clock cycles, where D is the active divider value. While bit 0 is clear, the counter holds its value.
- R4: The counter counts 0, 1, up to the active limit and then wraps to 0. The wrap is an update event, and it sets status bit 0 (update flag).
- R5: While control bit 1 (update suppress) is set, the counter still wraps. The wrap then sets no update flag, loads no limit and does not stop a one-pulse run.
- R6: A value written to the divider register is stored but not used until software writes 1 to bit 0 of the event trigger register. That write forces an update event: the divider value and buffered limit become active, the counter and divider phase go to 0, and the update flag is set.
- R7: While control bit 7 (limit buffering) is set, a limit write is held until the next update event. While bit 7 is clear, a limit write takes effect at once.
- R8: While control bit 3 (one-pulse) is set, an update event clears control bit 0, so the counter stops at 0 after the wrap.
- R9: When the counter steps onto the match register value, status bit 1 (match flag) is set and counting goes on. The match recurs every limit+1 counts.
- R10: A status write clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. A flag set by hardware in the same cycle as a clear stays set.
- R11: `irqOut` is registered and equals the OR over flags of (flag AND its enable bit) one cycle earlier. Enable bit 0 goes with the update flag and bit 1 with the match flag. Writing 0 to the enable register masks the interrupt.
- R12: A write to the counter register loads the low CNT_W bits directly into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe; read data is valid while it is high |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, 0 when not reading |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The bench counts every counter tick from the edge at which the enable write lands. An off-by-one in the divider compare or the wrap compare therefore shows up as a wrong count or as an update flag set one step early or late. It writes a new divider value and runs before forcing an update, which catches a design that uses the new value right away. It runs with a buffered limit that is below the current count, which catches a design that applies the new limit immediately. It places a status clear on the exact edge at which the match fires, so a design that lets the clear win loses the match flag. It also checks that suppressed updates leave the flag alone and that one-pulse mode leaves the counter stopped at zero with the enable bit reading back clear.

// File: rtl/utimer_pkg.sv
package utimer_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_IEN   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_EVGEN = 8'h14;
  localparam logic [7:0] OFS_COUNT = 8'h24;
  localparam logic [7:0] OFS_DIV   = 8'h28;
  localparam logic [7:0] OFS_LIMIT = 8'h2C;
  localparam logic [7:0] OFS_MATCH = 8'h34;

  localparam int BIT_RUN     = 0;
  localparam int BIT_NOUPD   = 1;
  localparam int BIT_ONESHOT = 3;
  localparam int BIT_BUFLIM  = 7;

  localparam int DIV_W = 16;

  typedef struct packed {
    logic countWr;
    logic limitWrNow;
    logic forceUpd;
  } dpStrobe_t;
endpackage

// File: rtl/utimer_dp.sv
module utimer_dp
  import utimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             noUpd,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wrVal,
  input  logic [DIV_W-1:0] divReg,
  input  logic [CNT_W-1:0] limitReg,
  input  logic [CNT_W-1:0] matchReg,
  output logic [CNT_W-1:0] cntVal,
  output logic             updEvt,
  output logic             cmpEvt
);
  logic [DIV_W-1:0] divAct, divCnt;
  logic [CNT_W-1:0] cnt, limitAct, stepVal;
  logic tick, atLimit, wrapEvt;

  assign tick    = cntEn && (divCnt == divAct);
  assign atLimit = (cnt == limitAct);
  assign wrapEvt = tick && atLimit;
  assign stepVal = atLimit ? '0 : cnt + 1'b1;
  assign updEvt  = (wrapEvt && !noUpd) || stb.forceUpd;
  assign cmpEvt  = tick && !stb.countWr && !stb.forceUpd && (stepVal == matchReg);
  assign cntVal  = cnt;

  // Divider phase and active divide value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      divAct <= '0;
    end else if (stb.forceUpd) begin
      divCnt <= '0;
      divAct <= divReg;
    end else if (cntEn) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  // Main counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.countWr) begin
      cnt <= wrVal;
    end else if (stb.forceUpd) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= stepVal;
    end
  end

  // Active limit: immediate write or load on update event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitAct <= '1;
    end else if (stb.limitWrNow) begin
      limitAct <= wrVal;
    end else if (updEvt) begin
      limitAct <= limitReg;
    end
  end
endmodule

// File: rtl/utimer_ctrl.sv
module utimer_ctrl
  import utimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output dpStrobe_t         stb,
  output logic              cntEn,
  output logic              noUpd,
  output logic              oneShot,
  output logic [DIV_W-1:0]  divReg,
  output logic [CNT_W-1:0]  limitReg,
  output logic [CNT_W-1:0]  matchReg,
  output logic [1:0]        flags,
  output logic [1:0]        ienBits,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              updEvt,
  input  logic              cmpEvt
);
  localparam int PAD_W = 32 - CNT_W;

  logic bufLim, irqQ;
  logic wrCtrl, wrIen, wrStat, wrEvgen, wrCount, wrDiv, wrLimit, wrMatch;

  function automatic logic [31:0] zext(input logic [CNT_W-1:0] v);
    logic [31:0] r;
    r = '0;
    r[CNT_W-1:0] = v;
    return r;
  endfunction

  assign wrCtrl  = busWr && (busAddr == ADDR_W'(OFS_CTRL));
  assign wrIen   = busWr && (busAddr == ADDR_W'(OFS_IEN));
  assign wrStat  = busWr && (busAddr == ADDR_W'(OFS_STAT));
  assign wrEvgen = busWr && (busAddr == ADDR_W'(OFS_EVGEN));
  assign wrCount = busWr && (busAddr == ADDR_W'(OFS_COUNT));
  assign wrDiv   = busWr && (busAddr == ADDR_W'(OFS_DIV));
  assign wrLimit = busWr && (busAddr == ADDR_W'(OFS_LIMIT));
  assign wrMatch = busWr && (busAddr == ADDR_W'(OFS_MATCH));

  assign stb.countWr    = wrCount;
  assign stb.limitWrNow = wrLimit && !bufLim;
  assign stb.forceUpd   = wrEvgen && busWdata[0];
  assign irqOut         = irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEn    <= 1'b0;
      noUpd    <= 1'b0;
      oneShot  <= 1'b0;
      bufLim   <= 1'b0;
      ienBits  <= '0;
      flags    <= '0;
      divReg   <= '0;
      limitReg <= '1;
      matchReg <= '0;
      irqQ     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        cntEn   <= busWdata[BIT_RUN];
        noUpd   <= busWdata[BIT_NOUPD];
        oneShot <= busWdata[BIT_ONESHOT];
        bufLim  <= busWdata[BIT_BUFLIM];
      end else if (updEvt && oneShot) begin
        cntEn <= 1'b0;
      end
      if (wrIen)   ienBits  <= busWdata[1:0];
      if (wrDiv)   divReg   <= busWdata[DIV_W-1:0];
      if (wrLimit) limitReg <= busWdata[CNT_W-1:0];
      if (wrMatch) matchReg <= busWdata[CNT_W-1:0];
      flags <= (wrStat ? (flags & busWdata[1:0]) : flags) | {cmpEvt, updEvt};
      irqQ  <= |(flags & ienBits);
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        ADDR_W'(OFS_CTRL):  begin
          busRdata[BIT_RUN]     = cntEn;
          busRdata[BIT_NOUPD]   = noUpd;
          busRdata[BIT_ONESHOT] = oneShot;
          busRdata[BIT_BUFLIM]  = bufLim;
        end
        ADDR_W'(OFS_IEN):   busRdata[1:0] = ienBits;
        ADDR_W'(OFS_STAT):  busRdata[1:0] = flags;
        ADDR_W'(OFS_COUNT): busRdata = zext(cntVal);
        ADDR_W'(OFS_DIV):   busRdata[DIV_W-1:0] = divReg;
        ADDR_W'(OFS_LIMIT): busRdata = zext(limitReg);
        ADDR_W'(OFS_MATCH): busRdata = zext(matchReg);
        default:            busRdata = '0;
      endcase
    end
  end

  if (PAD_W < 0) begin : g_badWidth
    initial $error("CNT_W above 32");
  end
endmodule

// File: rtl/utimer.sv
module utimer
  import utimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);
  dpStrobe_t        stb;
  logic             cntEn, noUpd, oneShot, updEvt, cmpEvt;
  logic [DIV_W-1:0] divReg;
  logic [CNT_W-1:0] limitReg, matchReg, cntVal;
  logic [1:0]       flags, ienBits;

  utimer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .stb(stb),
    .cntEn(cntEn), .noUpd(noUpd), .oneShot(oneShot), .divReg(divReg),
    .limitReg(limitReg), .matchReg(matchReg), .flags(flags), .ienBits(ienBits),
    .cntVal(cntVal), .updEvt(updEvt), .cmpEvt(cmpEvt)
  );

  utimer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .noUpd(noUpd), .stb(stb),
    .wrVal(busWdata[CNT_W-1:0]), .divReg(divReg), .limitReg(limitReg),
    .matchReg(matchReg), .cntVal(cntVal), .updEvt(updEvt), .cmpEvt(cmpEvt)
  );
endmodule

// File: rtl/utimer_chk.sv
module utimer_chk
  import utimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              irqOut,
  input logic [1:0]        flags,
  input logic [1:0]        ienBits,
  input logic              updEvt,
  input logic              cmpEvt,
  input logic              cntEn,
  input logic              oneShot,
  input dpStrobe_t         stb,
  input logic [CNT_W-1:0]  cntVal
);
  assert_irq_tracks_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(flags & ienBits))));

  assert_upd_sets_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> flags[0]);

  assert_match_sets_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmpEvt |=> flags[1]);

  assert_oneshot_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (updEvt && oneShot && !(busWr && busAddr == ADDR_W'(OFS_CTRL))) |=> !cntEn);

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !stb.countWr && !stb.forceUpd) |=> $stable(cntVal));

  assert_trigger_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(OFS_EVGEN)) |-> (busRdata == 32'd0));
endmodule

bind utimer utimer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .busRdata(busRdata), .irqOut(irqOut), .flags(flags), .ienBits(ienBits),
  .updEvt(updEvt), .cmpEvt(cmpEvt), .cntEn(cntEn), .oneShot(oneShot),
  .stb(stb), .cntVal(cntVal)
);

// File: tb/utimer_bench.sv
module utimer_bench;
  import utimer_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [31:0] expVal[$];
  string expTag[$];

  always #10 clk = ~clk;

  utimer u_utimer (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  // Driver: issues the read and queues the expected word
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    busRd = 1'b1; busAddr = a;
    expVal.push_back(e);
    expTag.push_back(tag);
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  // Enable counting for exactly k counter-clock edges (k >= 2)
  task automatic runFor(input int k, input logic [31:0] bits);
    wr(OFS_CTRL, bits | 32'h1);
    repeat (k - 2) @(posedge clk);
    wr(OFS_CTRL, bits);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    @(negedge clk);
    nRun++;
    if (irqOut !== e) begin
      nFail++;
      $display("FAIL %s irqOut actual=%0b expected=%0b", tag, irqOut, e);
    end
  endtask

  // Monitor: pops the expectation for each read and compares
  always @(negedge clk) begin
    if (busRd && expVal.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expVal.pop_front();
      t = expTag.pop_front();
      nRun++;
      if (busRdata !== e) begin
        nFail++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", t, busRdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    chkIrq(1'b0, "R1 irq after reset");
    rd(OFS_CTRL, 32'h0, "R1 control");
    rd(OFS_STAT, 32'h0, "R1 status");
    rd(OFS_COUNT, 32'h0, "R1 counter");
    rd(OFS_LIMIT, 32'h0000FFFF, "R1 limit");

    // R2 truncation and trigger readback
    wr(OFS_LIMIT, 32'hFFFFFFFF);
    rd(OFS_LIMIT, 32'h0000FFFF, "R2 limit width");
    wr(OFS_MATCH, 32'hFFFF1234);
    rd(OFS_MATCH, 32'h00001234, "R2 match width");
    rd(OFS_EVGEN, 32'h0, "R2 trigger reads 0");
    wr(OFS_LIMIT, 32'd9);

    // R3/R4 counting and wrap
    runFor(7, 0);
    rd(OFS_COUNT, 32'd7, "R3 count after 7 ticks");
    rd(OFS_STAT, 32'h0, "R4 no update before wrap");
    repeat (5) @(posedge clk);
    rd(OFS_COUNT, 32'd7, "R3 holds while disabled");
    runFor(5, 0);
    rd(OFS_COUNT, 32'd2, "R4 wrapped count");
    rd(OFS_STAT, 32'h1, "R4 update flag at wrap");

    // R11 interrupt gating, R10 flag clearing
    chkIrq(1'b0, "R11 masked irq");
    wr(OFS_IEN, 32'h1);
    repeat (2) @(posedge clk);
    chkIrq(1'b1, "R11 update irq");
    wr(OFS_STAT, 32'h3);
    rd(OFS_STAT, 32'h1, "R10 write one keeps flag");
    wr(OFS_STAT, 32'h2);
    rd(OFS_STAT, 32'h0, "R10 write zero clears");
    repeat (2) @(posedge clk);
    chkIrq(1'b0, "R11 irq drops after clear");
    wr(OFS_IEN, 32'h0);

    // R9 match
    wr(OFS_MATCH, 32'd4);
    runFor(2, 0);
    rd(OFS_COUNT, 32'd4, "R9 count at match");
    rd(OFS_STAT, 32'h2, "R9 match flag");
    wr(OFS_IEN, 32'h2);
    repeat (2) @(posedge clk);
    chkIrq(1'b1, "R11 match irq");
    wr(OFS_IEN, 32'h0);
    repeat (2) @(posedge clk);
    chkIrq(1'b0, "R11 enable zero masks");
    wr(OFS_STAT, 32'h0);
    runFor(10, 0);
    rd(OFS_COUNT, 32'd4, "R9 modular count");
    rd(OFS_STAT, 32'h3, "R9 match recurs after wrap");
    wr(OFS_STAT, 32'h0);

    // R5 update suppress
    wr(OFS_MATCH, 32'h1234);
    runFor(8, 32'h2);
    rd(OFS_COUNT, 32'd2, "R5 still wraps");
    rd(OFS_STAT, 32'h0, "R5 no update flag");
    wr(OFS_CTRL, 32'h0);

    // R6 divider only via forced update
    wr(OFS_DIV, 32'h12340003);
    runFor(4, 0);
    rd(OFS_COUNT, 32'd6, "R6 old divider still active");
    rd(OFS_DIV, 32'h3, "R2 divider width");
    wr(OFS_EVGEN, 32'h1);
    rd(OFS_COUNT, 32'd0, "R6 forced update zeroes counter");
    rd(OFS_STAT, 32'h1, "R6 forced update flag");
    runFor(8, 0);
    rd(OFS_COUNT, 32'd2, "R3 divide by four");
    wr(OFS_DIV, 32'h0);
    wr(OFS_EVGEN, 32'h1);
    wr(OFS_STAT, 32'h0);

    // R7 limit buffering
    wr(OFS_CTRL, 32'h80);
    wr(OFS_LIMIT, 32'd3);
    runFor(6, 32'h80);
    rd(OFS_COUNT, 32'd6, "R7 buffered limit not active");
    rd(OFS_LIMIT, 32'd3, "R7 limit readback");
    runFor(4, 32'h80);
    rd(OFS_COUNT, 32'd0, "R7 wrap at old limit");
    rd(OFS_STAT, 32'h1, "R7 update at wrap");
    runFor(5, 32'h80);
    rd(OFS_COUNT, 32'd1, "R7 new limit after update");
    wr(OFS_CTRL, 32'h0);
    wr(OFS_LIMIT, 32'd9);
    wr(OFS_STAT, 32'h0);
    runFor(5, 0);
    rd(OFS_COUNT, 32'd6, "R7 immediate limit");

    // R8 one-pulse
    wr(OFS_CTRL, 32'h9);
    repeat (20) @(posedge clk);
    rd(OFS_CTRL, 32'h8, "R8 enable cleared");
    rd(OFS_COUNT, 32'd0, "R8 stopped at zero");
    rd(OFS_STAT, 32'h1, "R8 update flag");
    wr(OFS_CTRL, 32'h0);
    wr(OFS_STAT, 32'h0);

    // R12 direct counter write
    wr(OFS_COUNT, 32'h000ABCDE);
    rd(OFS_COUNT, 32'h0000BCDE, "R12 counter write");
    wr(OFS_COUNT, 32'h0);

    // R10 hardware set wins over same-cycle clear
    wr(OFS_MATCH, 32'd3);
    wr(OFS_CTRL, 32'h1);
    @(posedge clk);
    wr(OFS_STAT, 32'h0);
    wr(OFS_CTRL, 32'h0);
    rd(OFS_STAT, 32'h2, "R10 set beats clear");
    rd(OFS_COUNT, 32'd5, "R10 count at stop");

    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule